// File: doc/BRIEF.md
# Ramp-Driven Converter Line Fitter

This block characterises an analog-to-digital converter while a rising analog ramp drives the converter's input. It watches the stream of output codes and marks where the usable samples begin and end. It then splits the usable samples into two halves of equal length and sums each half. From the two sums it forms two syndromes: the difference of the sums and their total. It derives the slope and intercept of the straight line `y = a*k + b` that best describes the converter's response. The index `k` counts the usable samples from zero.

The results are signed fixed-point numbers with `FRAC` fractional bits. Each usable sample is kept in a local buffer. If requested, a second pass compares every kept sample against the fitted line and fails the run when any sample lies further from the line than a programmable limit. A run also fails when the window holds fewer samples than a quarter of the converter's code range. A run ends with an error when the full-scale code does not arrive in time.

The buffer holds `DEPTH` samples (`DEPTH` must be a power of two). Samples beyond that are not kept and are not counted. A run starts with a one-cycle `start` pulse and ends with a one-cycle `done` pulse. The results hold until the next run is accepted.

Top module: `ramp_adc_fit`

## Requirements
- R1: After `start` is accepted, samples with code 0 are ignored. The first valid sample with a non-zero code below full scale becomes sample index 0. Later zero codes inside the window count as usable samples.
- R2: The window closes on the first valid sample whose code is all ones (`2^W-1`). That sample and the leading zeros are not counted. Cycles with `smp_vld` low are ignored, whatever their code.
- R3: When the window holds an odd number of samples, the last sample is dropped. `nsamp` reports the even count `n` actually used, and the halves hold `m = n/2` samples each.
- R4: `slope` equals `trunc(|s1-s0| * 2^FRAC / m^2)` and takes the sign of `s1-s0`. Here `s0` is the sum of samples `0..m-1` and `s1` is the sum of samples `m..n-1`.
- R5: `icpt` equals `trunc((s0+s1) * 2^FRAC / n) - ((slope*(n-1)) >>> 1)`. The `>>>` is an arithmetic shift, so the subtracted term is rounded toward minus infinity.
- R6: When `n < 2^(W-2)`, `pass` is 0 and both `slope` and `icpt` are 0.
- R7: With `chk_en` high, `pass` is 0 if any used sample `k` gives `|y_k*2^FRAC - (icpt + slope*k)| > tol*2^FRAC`. With `chk_en` low, no sample comparison affects `pass`.
- R8: If the full-scale code has not arrived `tmo_lim` cycles after `start` is accepted, the run ends with `err` = 1 and `pass` = 0.
- R9: `done` pulses for exactly one cycle, in the first cycle that `busy` is low. `slope`, `icpt`, `nsamp`, `pass` and `err` stay unchanged until the next `start` is accepted.
- R10: A `start` pulse that arrives while `busy` is high has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (accepted only while idle) |
| smp_vld | input | 1 | Converter sample strobe |
| smp_code | input | W | Converter output code |
| chk_en | input | 1 | Enable per-sample comparison against the fitted line; hold steady during a run |
| tol | input | W | Deviation limit in codes; hold steady during a run |
| tmo_lim | input | TW | Timeout in cycles, counted from start until the full-scale code arrives |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| slope | output | AW+W+FRAC+1 | Signed fitted slope, FRAC fractional bits |
| icpt | output | AW+W+FRAC+1 | Signed fitted intercept at k=0, FRAC fractional bits |
| nsamp | output | AW+1 | Even sample count used by the fit |
| pass | output | 1 | Run passed |
| err | output | 1 | Timeout occurred |

## Verification
An ideal one-code-per-sample ramp gives an exact slope and intercept of 1.0. A staircase that repeats each code three times, has an odd length and has gaps in the strobe tests the dropped sample, the idle-cycle rule and the fractional slope. A ramp with a local bump is run twice, once with the comparison enabled and once with it disabled, to show that only the comparison fails that ramp. A falling sequence that passes through zeros checks the sign of the slope and that zeros inside the window are counted. Short windows on either side of the `2^(W-2)` threshold, an immediate full-scale code, a stream with no full-scale code, and a `start` pulse in the middle of a run cover the remaining boundaries.

// File: rtl/ramp_adc_fit.sv
module ramp_adc_fit #(
  parameter int W     = 8,
  parameter int DEPTH = 512,
  parameter int FRAC  = 8,
  parameter int TW    = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          smp_vld,
  input  logic [W-1:0]                  smp_code,
  input  logic                          chk_en,
  input  logic [W-1:0]                  tol,
  input  logic [TW-1:0]                 tmo_lim,
  output logic                          busy,
  output logic                          done,
  output logic [$clog2(DEPTH)+W+FRAC:0] slope,
  output logic [$clog2(DEPTH)+W+FRAC:0] icpt,
  output logic [$clog2(DEPTH):0]        nsamp,
  output logic                          pass,
  output logic                          err
);
  localparam int AW   = $clog2(DEPTH);
  localparam int SW   = AW + W;
  localparam int NW   = SW + FRAC;
  localparam int CW   = NW + 1;
  localparam int PW   = CW + AW + 2;
  localparam int DCW  = $clog2(NW);
  localparam int MINS = 2 ** (W - 2);
  localparam logic [W-1:0] MAXC = '1;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_CAPT, S_SUM, S_DIVA, S_DIVB, S_CHK, S_FIN} st_t;
  st_t st;

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   cnt, idx, nsamp_r;
  logic [TW-1:0] tmr;
  logic [SW-1:0] s0, s1;
  logic [NW-1:0] dnum, dden, drem;
  logic [NW-2:0] quo;
  logic [DCW-1:0] dcnt;
  logic signed [CW-1:0] slope_r, icpt_r;
  logic dev, err_r, pass_r, done_r;

  wire [AW:0]   neff = {cnt[AW:1], 1'b0};
  wire [AW-1:0] half = cnt[AW:1];
  wire [W-1:0]  ycur = mem[idx[AW-1:0]];
  wire end_code = smp_vld && smp_code == MAXC;
  wire wen = smp_vld && smp_code != MAXC &&
             ((st == S_WAIT && smp_code != '0) || (st == S_CAPT && cnt < (AW+1)'(DEPTH)));

  wire signed [SW:0] sdiff = $signed({1'b0, s1}) - $signed({1'b0, s0});
  wire [SW-1:0] sdabs = sdiff[SW] ? SW'(-sdiff) : sdiff[SW-1:0];

  wire [NW:0]   rtry  = {drem, dnum[NW-1]};
  wire          dge   = rtry >= {1'b0, dden};
  wire [NW-1:0] qfin  = {quo, dge};
  wire          dlast = dcnt == DCW'(NW - 1);

  wire signed [PW-1:0] sxn  = PW'(slope_r) * PW'($signed({1'b0, neff - 1'b1}));
  wire signed [PW-1:0] pred = PW'(icpt_r) + PW'(slope_r) * PW'($signed({1'b0, idx}));
  wire signed [PW-1:0] yfx  = $signed(PW'({ycur, FRAC'(0)}));
  wire signed [PW-1:0] diff = yfx - pred;
  wire [PW-1:0] adiff = diff[PW-1] ? -diff : diff;
  wire over = adiff > PW'({tol, FRAC'(0)});

  always_ff @(posedge clk) if (wen) mem[cnt[AW-1:0]] <= smp_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; tmr <= '0; s0 <= '0; s1 <= '0;
      dnum <= '0; dden <= '0; drem <= '0; quo <= '0; dcnt <= '0;
      slope_r <= '0; icpt_r <= '0; nsamp_r <= '0;
      dev <= 1'b0; err_r <= 1'b0; pass_r <= 1'b0; done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (wen) cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st <= S_WAIT; cnt <= '0; tmr <= '0; s0 <= '0; s1 <= '0;
          slope_r <= '0; icpt_r <= '0; nsamp_r <= '0;
          dev <= 1'b0; err_r <= 1'b0; pass_r <= 1'b0;
        end
        S_WAIT, S_CAPT: begin
          tmr <= tmr + 1'b1;
          if (end_code) begin
            idx <= '0;
            st  <= (cnt < (AW+1)'(MINS)) ? S_FIN : S_SUM;
          end else if (tmr >= tmo_lim) begin
            err_r <= 1'b1; st <= S_FIN;
          end else if (wen && st == S_WAIT) st <= S_CAPT;
        end
        S_SUM: if (idx == neff) begin
          dnum <= {sdabs, FRAC'(0)}; dden <= NW'(half) * NW'(half);
          drem <= '0; dcnt <= '0; st <= S_DIVA;
        end else begin
          if (idx < {1'b0, half}) s0 <= s0 + SW'(ycur);
          else                    s1 <= s1 + SW'(ycur);
          idx <= idx + 1'b1;
        end
        S_DIVA, S_DIVB: begin
          drem <= NW'(dge ? rtry - {1'b0, dden} : rtry);
          dnum <= {dnum[NW-2:0], 1'b0};
          quo  <= qfin[NW-2:0];
          dcnt <= dcnt + 1'b1;
          if (dlast) begin
            dcnt <= '0; drem <= '0;
            if (st == S_DIVA) begin
              slope_r <= sdiff[SW] ? -$signed({1'b0, qfin}) : $signed({1'b0, qfin});
              dnum <= {s0 + s1, FRAC'(0)}; dden <= NW'(neff); st <= S_DIVB;
            end else begin
              icpt_r <= $signed({1'b0, qfin}) - CW'(sxn >>> 1);
              idx <= '0; st <= chk_en ? S_CHK : S_FIN;
            end
          end
        end
        S_CHK: begin
          if (over) dev <= 1'b1;
          idx <= idx + 1'b1;
          if (idx == neff - 1'b1) st <= S_FIN;
        end
        S_FIN: begin
          done_r <= 1'b1; nsamp_r <= neff; st <= S_IDLE;
          pass_r <= !err_r && !dev && cnt >= (AW+1)'(MINS);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy  = st != S_IDLE;
  assign done  = done_r;
  assign slope = slope_r;
  assign icpt  = icpt_r;
  assign nsamp = nsamp_r;
  assign pass  = pass_r;
  assign err   = err_r;
endmodule

module ramp_adc_fit_chk #(
  parameter int W     = 8,
  parameter int DEPTH = 512,
  parameter int FRAC  = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          start,
  input logic                          busy,
  input logic                          done,
  input logic                          pass,
  input logic                          err,
  input logic [$clog2(DEPTH):0]        nsamp,
  input logic [$clog2(DEPTH)+W+FRAC:0] slope,
  input logic [$clog2(DEPTH)+W+FRAC:0] icpt
);
  localparam int AW   = $clog2(DEPTH);
  localparam int MINS = 2 ** (W - 2);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r9:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(slope) && $stable(icpt) && $stable(pass) && $stable(err) && $stable(nsamp)));
  p_err_fail_r8: assert property (@(posedge clk) disable iff (!rst_n) (done && err) |-> !pass);
  p_few_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nsamp < (AW+1)'(MINS)) |-> (!pass && slope == '0 && icpt == '0));
  p_even_r3: assert property (@(posedge clk) disable iff (!rst_n) done |-> !nsamp[0]);
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> busy);
endmodule

bind ramp_adc_fit ramp_adc_fit_chk #(.W(W), .DEPTH(DEPTH), .FRAC(FRAC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
  .err(err), .nsamp(nsamp), .slope(slope), .icpt(icpt));

// File: tb/ramp_adc_fit_tb.sv
module ramp_adc_fit_tb;
  localparam int W = 8, DEPTH = 512, FRAC = 8, TW = 20;
  localparam int AW = 9, CW = AW + W + FRAC + 1;
  localparam int MAXC = 255, MINS = 64;

  logic clk = 0, rst_n = 0, start = 0, smp_vld = 0, chk_en = 0;
  logic [W-1:0] smp_code = '0, tol = '0;
  logic [TW-1:0] tmo_lim = '0;
  wire busy, done, pass, err;
  wire [CW-1:0] slope, icpt;
  wire [AW:0] nsamp;

  always #4 clk = ~clk;

  ramp_adc_fit #(.W(W), .DEPTH(DEPTH), .FRAC(FRAC), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_vld(smp_vld), .smp_code(smp_code),
    .chk_en(chk_en), .tol(tol), .tmo_lim(tmo_lim), .busy(busy), .done(done),
    .slope(slope), .icpt(icpt), .nsamp(nsamp), .pass(pass), .err(err));

  int checks = 0, fails = 0, cyc = 0, ndone = 0;
  bit streaming = 0, finished = 0;
  longint e_slope, e_icpt;
  int e_n;
  bit e_pass, e_err;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R9 watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  always @(negedge clk) begin
    if (done) ndone++;
    if (streaming && !e_err) chk(!done, "R2 done before window closed", done, 0);
  end

  task automatic model(input int q[$], input bit ce, input int tl);
    int v[$];
    bit started = 0, ended = 0;
    longint s0 = 0, s1 = 0, d, qa;
    int m;
    foreach (q[i]) begin
      if (ended) break;
      if (q[i] == MAXC) ended = 1;
      else if (started || q[i] != 0) begin started = 1; v.push_back(q[i]); end
    end
    e_err = !ended;
    e_n = v.size() & ~1;
    m = e_n / 2;
    e_slope = 0; e_icpt = 0;
    if (e_err || e_n < MINS) begin e_pass = 0; return; end
    for (int k = 0; k < e_n; k++) if (k < m) s0 += v[k]; else s1 += v[k];
    d = s1 - s0;
    qa = ((d < 0 ? -d : d) <<< FRAC) / (m * m);
    e_slope = d < 0 ? -qa : qa;
    e_icpt = ((s0 + s1) <<< FRAC) / e_n - ((e_slope * (e_n - 1)) >>> 1);
    e_pass = 1;
    if (ce)
      for (int k = 0; k < e_n; k++) begin
        longint df;
        df = (longint'(v[k]) <<< FRAC) - (e_icpt + e_slope * k);
        if ((df < 0 ? -df : df) > (longint'(tl) <<< FRAC)) e_pass = 0;
      end
  endtask

  task automatic run(input string name, input int q[$], input bit ce, input int tl,
                     input int tmo, input bit gaps, input int start_at);
    int nd0, wait_c;
    model(q, ce, tl);
    @(negedge clk);
    chk_en = ce; tol = W'(tl); tmo_lim = TW'(tmo); start = 1;
    nd0 = ndone;
    @(negedge clk);
    start = 0;
    streaming = 1;
    foreach (q[i]) begin
      if (gaps && i % 3 == 0) begin
        smp_vld = 0; smp_code = W'(MAXC);
        @(negedge clk);
      end
      smp_vld = 1; smp_code = W'(q[i]); start = (i == start_at);
      @(negedge clk);
    end
    smp_vld = 0; smp_code = '0; start = 0;
    streaming = 0;
    wait_c = 0;
    while (ndone == nd0 && wait_c < 5000) begin @(negedge clk); wait_c++; end
    chk(ndone > nd0, {"R9 done seen ", name}, ndone - nd0, 1);
    chk(err == e_err, {"R8 err ", name}, err, e_err);
    chk(pass == e_pass, {"R7 pass ", name}, pass, e_pass);
    if (!e_err) begin
      chk(nsamp == e_n, {"R3 nsamp ", name}, nsamp, e_n);
      chk($signed(slope) == e_slope, {"R4 slope ", name}, $signed(slope), e_slope);
      chk($signed(icpt) == e_icpt, {"R5 icpt ", name}, $signed(icpt), e_icpt);
    end
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!done && !busy, {"R9 single pulse ", name}, done, 0);
      chk(pass == e_pass && err == e_err, {"R9 hold ", name}, pass, e_pass);
    end
  endtask

  initial begin
    int q[$];
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !err && slope == 0 && nsamp == 0, "R9 reset state", busy, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R4 R5: ideal ramp, slope and intercept both 1.0
    q = {0, 0, 0, 0};
    for (int c = 1; c < MAXC; c++) q.push_back(c);
    q.push_back(MAXC);
    run("ideal", q, 1, 0, 100000, 0, -1);
    chk($signed(slope) == 256 && $signed(icpt) == 256, "R4 R5 unity line", $signed(slope), 256);

    // R3 R2 R10: staircase, odd length, strobe gaps, start pulse mid-run
    q = {0, 0, 0};
    for (int c = 3; c <= 130; c++) repeat (3) q.push_back(c);
    q.push_back(131);
    q.push_back(MAXC);
    run("staircase", q, 1, 1, 100000, 1, 200);
    chk(nsamp == 384, "R3 odd window trimmed", nsamp, 384);

    // R7: bump fails with compare on, ignored with compare off
    q = {0};
    for (int c = 1; c < MAXC; c++) q.push_back((c >= 100 && c <= 110) ? c + 8 : c);
    q.push_back(MAXC);
    run("bump_on", q, 1, 2, 100000, 0, -1);
    chk(pass == 0, "R7 bump detected", pass, 0);
    run("bump_off", q, 0, 2, 100000, 0, -1);
    chk(pass == 1, "R7 compare disabled", pass, 1);

    // R1 R4: falling sequence with zeros inside the window
    q = {0, 0};
    for (int c = 200; c >= 1; c--) q.push_back(c);
    repeat (20) q.push_back(0);
    q.push_back(MAXC);
    run("falling", q, 0, 0, 100000, 0, -1);
    chk($signed(slope) < 0 && nsamp == 220, "R1 zeros counted, R4 negative slope", nsamp, 220);

    // R6: short window and threshold boundaries
    q = {0};
    for (int c = 10; c <= 60; c++) q.push_back(c);
    q.push_back(MAXC);
    run("short", q, 0, 0, 100000, 0, -1);
    q = {};
    for (int c = 1; c <= MINS; c++) q.push_back(c);
    q.push_back(MAXC);
    run("at_min", q, 0, 0, 100000, 0, -1);
    chk(pass == 1, "R6 exactly minimum passes", pass, 1);
    q = {};
    for (int c = 1; c < MINS; c++) q.push_back(c);
    q.push_back(MAXC);
    run("below_min", q, 0, 0, 100000, 0, -1);
    chk(pass == 0 && slope == 0, "R6 below minimum fails", pass, 0);

    // R2: full scale as first non-zero code
    q = {0, 0, MAXC};
    run("immediate", q, 0, 0, 100000, 0, -1);
    chk(nsamp == 0, "R2 empty window", nsamp, 0);

    // R8: full scale never arrives
    q = {};
    for (int c = 0; c < 300; c++) q.push_back(c % 200 + 1);
    run("timeout", q, 0, 0, 200, 0, -1);
    chk(err == 1 && pass == 0, "R8 timeout flagged", err, 1);

    // recovery after timeout
    q = {};
    for (int c = 1; c < MAXC; c++) q.push_back(c);
    q.push_back(MAXC);
    run("recover", q, 1, 0, 100000, 0, -1);

    summary();
  end
endmodule